// File: doc/BRIEF.md
# Per-Task Register Bank Remapper

This block sits between the operand-address stage of a multithreaded core and its register file. Each instruction carries the ID of the hardware task that issued it, plus a destination (D) and a source (S) register address. When remapping is on, addresses that fall in a low window of the register file are moved into a bank that belongs to the issuing task. The same code can then run in several tasks at once, and each task reaches its own private copy of the variables. Software never adds a per-task base offset.

The bank geometry comes from a 7-bit configuration word. The word holds an enable flag, the log2 of the bank count and the log2 of the registers per bank. With the word `1_010_010` there are four banks of four registers. Task t then sees addresses 0..3 at physical 4t..4t+3, and every address from 16 upward is shared by all tasks. Both remapped addresses are registered, so results appear one clock after the inputs.

Top module: `task_bank_remap`

## Requirements
- R1: While reset is asserted both outputs are 0. After reset, remapping is disabled until a configuration word is written.
- R2: The configuration word is laid out as follows: bit 6 is the enable flag, bits 5:3 give tb (log2 of the bank count) and bits 2:0 give rb (log2 of the registers per bank). The word is stored at a rising edge where `cfg_we` is 1, and it is held whenever `cfg_we` is 0. A stored word applies to addresses presented after that edge. The address presented in the same cycle as the write still uses the previous word.
- R3: While remapping is disabled, each output equals its input address from the previous cycle.
- R4: While remapping is enabled, an address at or above 2^(tb+rb) passes through unchanged. When tb+rb is 9 or more, every address lies inside the window.
- R5: While remapping is enabled, an address inside the window maps to ((task_id mod 2^tb) << rb) | (addr mod 2^rb), truncated to 9 bits.
- R6: With the word 1_010_010, task t maps addresses 0..3 to 4t+0..4t+3, and address 16 or above is unchanged.
- R7: The D and S addresses are translated independently, in the same cycle, under the same task ID and word.
- R8: When tb exceeds the 2-bit task ID width, the whole task ID is used. When tb is 0, all tasks share bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_id | input | 2 | Task that issued the instruction |
| d_addr_i | input | 9 | Raw destination address |
| s_addr_i | input | 9 | Raw source address |
| cfg_we | input | 1 | Store `cfg_word` at this edge |
| cfg_word | input | 7 | {enable, tb[2:0], rb[2:0]} |
| d_addr_o | output | 9 | Remapped destination address |
| s_addr_o | output | 9 | Remapped source address |

## Verification
The embedded assertions check these properties on every cycle:
- pass-through while remapping is disabled;
- pass-through for addresses above the window;
- the low rb bits are preserved inside the window;
- a remapped result never leaves the window;
- the configuration register loads and holds its value;
- remapping is off at reset release.

Only the bench scenarios can show the full bank arithmetic for each geometry. The bench covers the four-by-four example, the one-cycle boundary between a configuration write and its first use, and the clamping of an oversized task field or a window of 9 bits or more. It also confirms that both ports agree under random traffic.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int ADDR_W  = 9;
  localparam int TASK_W  = 2;
  localparam int FIELD_W = 3;
  localparam int CFG_W   = 1 + 2 * FIELD_W;
  localparam int NPORT   = 2;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] bank_log2;
    logic [FIELD_W-1:0] reg_log2;
  } remap_cfg_t;
endpackage

// File: rtl/remap_rst_sync.sv
module remap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output remap_cfg_t       cfg_q
);
  remap_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = remap_cfg_t'(cfg_word);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_we |=> (cfg_q == $past(cfg_word))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    !cfg_we |=> $stable(cfg_q)); // R2
  AST_OFF_AT_START: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(rst_ns) |-> !cfg_q.en); // R1
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TASK_W
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  remap_cfg_t    cfg_i,
  input  logic [TW-1:0] task_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int SUM_W = FIELD_W + 1;
  localparam logic [SUM_W-1:0] AW_S = SUM_W'(AW);

  logic [SUM_W-1:0] span;
  logic [AW-1:0]    task_mask, task_ext, low_mask, banked;
  logic             in_win;
  logic [AW-1:0]    addr_d;

  always_comb begin
    span      = SUM_W'(cfg_i.bank_log2) + SUM_W'(cfg_i.reg_log2);
    task_mask = ~({AW{1'b1}} << cfg_i.bank_log2);
    task_ext  = AW'(task_i) & task_mask;
    low_mask  = ~({AW{1'b1}} << cfg_i.reg_log2);
    banked    = (task_ext << cfg_i.reg_log2) | (addr_i & low_mask);
    in_win    = (span >= AW_S) || ((addr_i >> span) == '0);
    addr_d    = (cfg_i.en && in_win) ? banked : addr_i;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) addr_o <= '0;
    else         addr_o <= addr_d;
  end

  AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_ns)
    !cfg_i.en |=> (addr_o == $past(addr_i))); // R3
  AST_ABOVE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_i.en && span < AW_S && (addr_i >> span) != '0)
      |=> (addr_o == $past(addr_i))); // R4
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_i.en && in_win)
      |=> ((addr_o & $past(low_mask)) == ($past(addr_i) & $past(low_mask)))); // R5
  AST_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (cfg_i.en && span < AW_S && (addr_i >> span) == '0)
      |=> ((addr_o >> $past(span)) == '0)); // R5
endmodule

// File: rtl/task_bank_remap.sv
module task_bank_remap
  import remap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int TW = TASK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    task_id,
  input  logic [AW-1:0]    d_addr_i,
  input  logic [AW-1:0]    s_addr_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  output logic [AW-1:0]    d_addr_o,
  output logic [AW-1:0]    s_addr_o
);
  logic          rst_ns;
  remap_cfg_t    cfg_q;
  logic [AW-1:0] raw   [NPORT];
  logic [AW-1:0] remap [NPORT];

  remap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  remap_cfg_reg u_cfg (
    .clk(clk), .rst_ns(rst_ns), .cfg_we(cfg_we),
    .cfg_word(cfg_word), .cfg_q(cfg_q)
  );

  assign raw[0] = d_addr_i;
  assign raw[1] = s_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    remap_xlate #(.AW(AW), .TW(TW)) u_xl (
      .clk(clk), .rst_ns(rst_ns), .cfg_i(cfg_q), .task_i(task_id),
      .addr_i(raw[p]), .addr_o(remap[p])
    );
  end

  assign d_addr_o = remap[0];
  assign s_addr_o = remap[1];

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ns |-> (d_addr_o == '0 && s_addr_o == '0)); // R1
endmodule

// File: tb/test_task_bank_remap.sv
module test_task_bank_remap;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] task_id;
  logic [8:0] d_addr_i, s_addr_i, d_addr_o, s_addr_o;
  logic       cfg_we;
  logic [6:0] cfg_word;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   m_cfg    = 0;
  int   exp_d, exp_s;
  bit   pend     = 0;
  string tag_d, tag_s;

  always #2.5 clk = ~clk;

  task_bank_remap i_task_bank_remap (
    .clk(clk), .rst_n(rst_n), .task_id(task_id),
    .d_addr_i(d_addr_i), .s_addr_i(s_addr_i),
    .cfg_we(cfg_we), .cfg_word(cfg_word),
    .d_addr_o(d_addr_o), .s_addr_o(s_addr_o)
  );

  function automatic int model(int cfg, int t, int a);
    int en, tb, rb;
    en = (cfg >> 6) & 1;
    tb = (cfg >> 3) & 7;
    rb = cfg & 7;
    if (en == 0) return a;
    if ((tb + rb) < 9 && a >= (1 << (tb + rb))) return a;
    return (((t % (1 << tb)) * (1 << rb)) + (a % (1 << rb))) % 512;
  endfunction

  function automatic string classify(int cfg, int a);
    int tb, rb;
    tb = (cfg >> 3) & 7;
    rb = cfg & 7;
    if (((cfg >> 6) & 1) == 0) return "R3";
    if ((tb + rb) < 9 && a >= (1 << (tb + rb))) return "R4";
    if (tb > 2 || tb == 0) return "R8";
    return "R5";
  endfunction

  task automatic check(string tg, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  task automatic step(int t, int d, int s, bit we, int w, string tg);
    @(negedge clk);
    if (pend) begin
      check(tag_d, int'(d_addr_o), exp_d);
      check(tag_s, int'(s_addr_o), exp_s);
    end
    task_id  = 2'(t);
    d_addr_i = 9'(d);
    s_addr_i = 9'(s);
    cfg_we   = we;
    cfg_word = 7'(w);
    exp_d = model(m_cfg, t, d);
    exp_s = model(m_cfg, t, s);
    tag_d = (tg != "") ? tg : classify(m_cfg, d);
    tag_s = (tg != "") ? tg : "R7";
    if (we) m_cfg = w;
    pend = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; task_id = 2'd3; d_addr_i = 9'h1ab; s_addr_i = 9'h0f3;
    cfg_we = 1'b1; cfg_word = 7'h7f;
    // R1: outputs held at zero while reset is asserted
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", int'(d_addr_o), 0);
      check("R1", int'(s_addr_o), 0);
    end
    @(negedge clk);
    rst_n = 1'b1; cfg_we = 1'b0; cfg_word = '0;
    d_addr_i = '0; s_addr_i = '0; task_id = '0;
    exp_d = 0; exp_s = 0; tag_d = "R1"; tag_s = "R1"; pend = 1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R1");
    // R1/R3: pass-through after reset
    for (int i = 0; i < 16; i++) step(i % 4, i * 29, 511 - i, 0, 0, "R3");
    // R6: four banks of four registers
    step(0, 0, 0, 1, 7'b1_010_010, "R6");
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 4; a++) step(t, a, 3 - a, 0, 0, "R6");
    for (int t = 0; t < 4; t++) step(t, 16, 511, 0, 0, "R6");
    // R2: write-cycle uses old word, later cycles use new one, hold when not written
    step(0, 0, 0, 1, 7'b0_000_000, "R2");
    step(2, 1, 2, 1, 7'b1_010_010, "R2");
    step(2, 1, 2, 0, 7'b0_111_111, "R2");
    step(2, 1, 2, 0, 7'b0_000_000, "R2");
    // R8: oversized and zero task fields
    step(0, 0, 0, 1, 7'b1_111_001, "R8");
    step(3, 5, 255, 0, 0, "R8");
    step(2, 256, 4, 0, 0, "R8");
    step(0, 0, 0, 1, 7'b1_000_011, "R8");
    for (int t = 0; t < 4; t++) step(t, 5, 8, 0, 0, "R8");
    // R4: window covering the whole space, and above-window pass-through
    step(0, 0, 0, 1, 7'b1_101_100, "R4");
    step(2, 511, 300, 0, 0, "R4");
    step(0, 0, 0, 1, 7'b1_001_010, "R4");
    step(1, 8, 7, 0, 0, "R4");
    // R5/R7: random traffic and configurations on both ports
    for (int i = 0; i < 3000; i++) begin
      bit we;
      int w, a;
      we = ($urandom_range(0, 15) == 0);
      w  = $urandom_range(0, 127);
      a  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 31) : $urandom_range(0, 511);
      step($urandom_range(0, 3), a, $urandom_range(0, 63), we, w, "");
    end
    // R3: disable again
    step(0, 0, 0, 1, 7'b0_010_010, "R3");
    for (int i = 0; i < 4; i++) step(i, i, i + 1, 0, 0, "R3");
    step(0, 0, 0, 0, 0, "R3");
    finish_run();
  end
endmodule